// File: doc/BRIEF.md
# Keyboard Scancode to Character Scanner

This block sits between a keyboard byte receiver and two consumers: a line-history buffer and a command parser. The receiver offers one scancode byte at a time, marked by a single-cycle strobe. The block follows the prefix bytes of the key stream: an extended-key marker, and a release marker whose next byte is thrown away. It decodes each finished make code through a small built-in table. A printable key becomes a character code that is handed to the history buffer. The backspace key becomes an erase request to the same buffer. The enter key asks the parser to run.

Each of the three requests is a four-phase handshake. A request is raised and held until its acknowledge rises. The request then drops, and the block waits for the acknowledge to fall. Only after that does it look at the next strobed byte. Any byte that arrives while a handshake is open is dropped, and it does not change the prefix state. Shift state is not tracked: letters always come out in one fixed case, chosen by a parameter.

Top module: `kbd_char_scanner`

## Requirements
- R1: After reset, `char_req`, `bksp_req` and `run_req` are low and `char_out` is zero.
- R2: A non-prefixed make code from the table below raises `char_req`, with the ASCII code on `char_out`, at the clock edge that samples the strobe. Table (code:char): 1C:a 32:b 21:c 23:d 24:e 2B:f 34:g 33:h 43:i 3B:j 42:k 4B:l 3A:m 31:n 44:o 4D:p 15:q 2D:r 1B:s 2C:t 3C:u 2A:v 1D:w 22:x 35:y 1A:z 45:0 16:1 1E:2 26:3 25:4 2E:5 36:6 3D:7 3E:8 46:9 29:space 41:',' 49:'.' 4A:'/' 4E:'-' 55:'=' 7C:'*' 79:'+' 7B:'-'. The default configuration gives lower-case letters.
- R3: `char_req` and `char_out` stay unchanged until `hist_ack` is sampled high. `char_req` falls at that edge. The block accepts no byte until it has sampled `hist_ack` low again.
- R4: Code 0x66 (backspace) raises `bksp_req` with the same acknowledge sequence as R3. `char_out` stays zero throughout.
- R5: Code 0x5A (enter) raises `run_req` and holds it until `run_done` is sampled high. It falls at that edge. The block then waits for `run_done` low before it accepts another byte.
- R6: Byte 0xE0 is a prefix and makes the next byte an extended key. In that case 0x4A gives '/' (0x2F), 0x5A gives the enter request of R5, and every other extended byte gives no request.
- R7: Byte 0xF0 is a release prefix. The next byte, extended or not, is discarded without a request.
- R8: A byte that is not in the table and not a prefix produces no request, and the block is ready for the following byte.
- R9: At most one of the three requests is high in any cycle. Strobed bytes are ignored while a handshake is open, including prefix bytes.
- R10: The prefix flags clear once the byte that follows them has been consumed. For example, after E0 1C, a later 1C gives 'a'.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_stb | input | 1 | Single-cycle strobe marking a valid scancode byte |
| key_code | input | 8 | Scancode byte, valid while key_stb is high |
| char_out | output | CHAR_W | Character code offered to the history buffer |
| char_req | output | 1 | Character take request |
| bksp_req | output | 1 | Erase request to the history buffer |
| hist_ack | input | 1 | Acknowledge from the history buffer, shared by both of its requests |
| run_req | output | 1 | Parser run request |
| run_done | input | 1 | Parser completion acknowledge |

## Verification
The assertions assume that every acknowledge follows the four-phase discipline. `hist_ack` rises only while `char_req` or `bksp_req` is high and falls only after the request has dropped. `run_done` behaves the same way with respect to `run_req`. The assertions also assume that a strobe lasts exactly one cycle. The stimulus keeps to this by raising each acknowledge only after it has seen the matching request, and by lowering it only after it has seen the request fall. Bytes sent while a handshake is open come only as isolated one-cycle strobes, so these assumptions hold at every edge.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

   typedef enum logic [1:0] {
      KEY_NONE  = 2'd0,
      KEY_CHAR  = 2'd1,
      KEY_BKSP  = 2'd2,
      KEY_ENTER = 2'd3
   } key_kind_t;

   typedef struct packed {
      key_kind_t  kind;
      logic [6:0] ascii;
   } key_info_t;

   function automatic key_info_t mk_char(input logic [6:0] a);
      key_info_t r;
      r.kind  = KEY_CHAR;
      r.ascii = a;
      return r;
   endfunction

   // make-code lookup, letters in lower case
   function automatic key_info_t scan_lookup(input logic [7:0] code, input logic ext);
      key_info_t r;
      r.kind  = KEY_NONE;
      r.ascii = 7'h00;
      if (ext) begin
         case (code)
            8'h4A:   r = mk_char(7'h2F);
            8'h5A:   r.kind = KEY_ENTER;
            default: r.kind = KEY_NONE;
         endcase
      end else begin
         case (code)
            8'h1C: r = mk_char("a");   8'h32: r = mk_char("b");
            8'h21: r = mk_char("c");   8'h23: r = mk_char("d");
            8'h24: r = mk_char("e");   8'h2B: r = mk_char("f");
            8'h34: r = mk_char("g");   8'h33: r = mk_char("h");
            8'h43: r = mk_char("i");   8'h3B: r = mk_char("j");
            8'h42: r = mk_char("k");   8'h4B: r = mk_char("l");
            8'h3A: r = mk_char("m");   8'h31: r = mk_char("n");
            8'h44: r = mk_char("o");   8'h4D: r = mk_char("p");
            8'h15: r = mk_char("q");   8'h2D: r = mk_char("r");
            8'h1B: r = mk_char("s");   8'h2C: r = mk_char("t");
            8'h3C: r = mk_char("u");   8'h2A: r = mk_char("v");
            8'h1D: r = mk_char("w");   8'h22: r = mk_char("x");
            8'h35: r = mk_char("y");   8'h1A: r = mk_char("z");
            8'h45: r = mk_char("0");   8'h16: r = mk_char("1");
            8'h1E: r = mk_char("2");   8'h26: r = mk_char("3");
            8'h25: r = mk_char("4");   8'h2E: r = mk_char("5");
            8'h36: r = mk_char("6");   8'h3D: r = mk_char("7");
            8'h3E: r = mk_char("8");   8'h46: r = mk_char("9");
            8'h29: r = mk_char(" ");   8'h41: r = mk_char(",");
            8'h49: r = mk_char(".");   8'h4A: r = mk_char("/");
            8'h4E: r = mk_char("-");   8'h55: r = mk_char("=");
            8'h7C: r = mk_char("*");   8'h79: r = mk_char("+");
            8'h7B: r = mk_char("-");
            8'h66: r.kind = KEY_BKSP;
            8'h5A: r.kind = KEY_ENTER;
            default: r.kind = KEY_NONE;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/kbd_prefix_track.sv
module kbd_prefix_track #(
   parameter logic [7:0] EXT_BYTE = 8'hE0,
   parameter logic [7:0] REL_BYTE = 8'hF0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept,
   input  logic [7:0] code,
   output logic       key_valid,
   output logic       key_ext
);

   logic ext_q;
   logic rel_q;
   logic is_ext;
   logic is_rel;

   assign is_ext    = (code == EXT_BYTE);
   assign is_rel    = (code == REL_BYTE);
   assign key_valid = accept && !is_ext && !is_rel && !rel_q;
   assign key_ext   = ext_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q <= 1'b0;
         rel_q <= 1'b0;
      end else if (accept) begin
         if (is_ext) begin
            ext_q <= 1'b1;
         end else if (is_rel) begin
            rel_q <= 1'b1;
         end else begin
            ext_q <= 1'b0;
            rel_q <= 1'b0;
         end
      end
   end

   // R9: prefix state is frozen whenever no byte is taken
   a_r9_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> ($stable(ext_q) && $stable(rel_q)));

   // R7: a byte after the release marker is never passed on as a key
   a_r7_release_drop: assert property (@(posedge clk) disable iff (!rst_n)
      rel_q |-> !key_valid);

endmodule

// File: rtl/kbd_key_decode.sv
module kbd_key_decode
   import kbd_scan_pkg::*;
#(
   parameter int CHAR_W     = 8,
   parameter bit UPPER_CASE = 1'b0
) (
   input  logic [7:0]        code,
   input  logic              ext,
   output key_kind_t         kind,
   output logic [CHAR_W-1:0] ch
);

   key_info_t  info;
   logic [6:0] folded;

   assign info = scan_lookup(code, ext);
   assign kind = info.kind;

   generate
      if (UPPER_CASE) begin : g_upper
         assign folded = ((info.ascii >= 7'h61) && (info.ascii <= 7'h7A)) ?
                         (info.ascii - 7'h20) : info.ascii;
      end else begin : g_lower
         assign folded = info.ascii;
      end
   endgenerate

   assign ch = CHAR_W'(folded);

endmodule

// File: rtl/kbd_hs_ctrl.sv
module kbd_hs_ctrl
   import kbd_scan_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_valid,
   input  key_kind_t         kind,
   input  logic [CHAR_W-1:0] ch,
   output logic              ready,
   output logic [CHAR_W-1:0] char_out,
   output logic              char_req,
   output logic              bksp_req,
   input  logic              hist_ack,
   output logic              run_req,
   input  logic              run_done
);

   typedef enum logic [2:0] {
      HS_IDLE, HS_CHAR, HS_BKSP, HS_ACK_LO, HS_RUN, HS_RUN_LO
   } hs_state_t;

   hs_state_t         state;
   logic [CHAR_W-1:0] char_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= HS_IDLE;
         char_q <= '0;
      end else begin
         case (state)
            HS_IDLE: if (key_valid) begin
               case (kind)
                  KEY_CHAR: begin
                     state  <= HS_CHAR;
                     char_q <= ch;
                  end
                  KEY_BKSP:  state <= HS_BKSP;
                  KEY_ENTER: state <= HS_RUN;
                  default:   state <= HS_IDLE;
               endcase
            end
            HS_CHAR: if (hist_ack) begin
               state  <= HS_ACK_LO;
               char_q <= '0;
            end
            HS_BKSP:   if (hist_ack)  state <= HS_ACK_LO;
            HS_ACK_LO: if (!hist_ack) state <= HS_IDLE;
            HS_RUN:    if (run_done)  state <= HS_RUN_LO;
            HS_RUN_LO: if (!run_done) state <= HS_IDLE;
            default:   state <= HS_IDLE;
         endcase
      end
   end

   assign ready    = (state == HS_IDLE);
   assign char_req = (state == HS_CHAR);
   assign bksp_req = (state == HS_BKSP);
   assign run_req  = (state == HS_RUN);
   assign char_out = char_q;

   // R9: never two requests at once
   a_r9_one_request: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({char_req, bksp_req, run_req}));

   // R3: character request and code held until acknowledged
   a_r3_char_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (char_req && !hist_ack) |=> (char_req && $stable(char_out)));

   // R3: request drops right after the acknowledge
   a_r3_char_release: assert property (@(posedge clk) disable iff (!rst_n)
      (char_req && hist_ack) |=> !char_req);

   // R4: erase request carries no character
   a_r4_bksp_no_char: assert property (@(posedge clk) disable iff (!rst_n)
      bksp_req |-> (char_out == '0));

   // R5: parser request held until completion, then dropped
   a_r5_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run_req && !run_done) |=> run_req);

   a_r5_run_release: assert property (@(posedge clk) disable iff (!rst_n)
      (run_req && run_done) |=> !run_req);

endmodule

// File: rtl/kbd_char_scanner.sv
module kbd_char_scanner
   import kbd_scan_pkg::*;
#(
   parameter int         CHAR_W     = 8,
   parameter bit         UPPER_CASE = 1'b0,
   parameter logic [7:0] EXT_BYTE   = 8'hE0,
   parameter logic [7:0] REL_BYTE   = 8'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_stb,
   input  logic [7:0]        key_code,
   output logic [CHAR_W-1:0] char_out,
   output logic              char_req,
   output logic              bksp_req,
   input  logic              hist_ack,
   output logic              run_req,
   input  logic              run_done
);

   initial begin
      assert (CHAR_W >= 7) else $error("CHAR_W must hold a 7-bit code");
      assert (EXT_BYTE != REL_BYTE) else $error("prefix bytes must differ");
   end

   logic              ready;
   logic              accept;
   logic              key_valid;
   logic              key_ext;
   key_kind_t         kind;
   logic [CHAR_W-1:0] ch;

   assign accept = key_stb && ready;

   kbd_prefix_track #(
      .EXT_BYTE (EXT_BYTE),
      .REL_BYTE (REL_BYTE)
   ) u_prefix (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .code      (key_code),
      .key_valid (key_valid),
      .key_ext   (key_ext)
   );

   kbd_key_decode #(
      .CHAR_W     (CHAR_W),
      .UPPER_CASE (UPPER_CASE)
   ) u_decode (
      .code (key_code),
      .ext  (key_ext),
      .kind (kind),
      .ch   (ch)
   );

   kbd_hs_ctrl #(
      .CHAR_W (CHAR_W)
   ) u_hs (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_valid (key_valid),
      .kind      (kind),
      .ch        (ch),
      .ready     (ready),
      .char_out  (char_out),
      .char_req  (char_req),
      .bksp_req  (bksp_req),
      .hist_ack  (hist_ack),
      .run_req   (run_req),
      .run_done  (run_done)
   );

   // R1: no request while held in reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> !(char_req || bksp_req || run_req));

endmodule

// File: tb/kbd_char_scanner_tb.sv
module kbd_char_scanner_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       key_stb = 1'b0;
   logic [7:0] key_code = 8'h00;
   logic [7:0] char_out;
   logic       char_req, bksp_req, run_req;
   logic       hist_ack = 1'b0;
   logic       run_done = 1'b0;

   int n_checks = 0;
   int n_fail = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   kbd_char_scanner u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_stb  (key_stb),
      .key_code (key_code),
      .char_out (char_out),
      .char_req (char_req),
      .bksp_req (bksp_req),
      .hist_ack (hist_ack),
      .run_req  (run_req),
      .run_done (run_done)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog actual=%0d expected<=150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // expected result: -1 none, -2 erase, -3 run, otherwise ASCII
   function automatic int exp_key(input int b, input bit ext);
      if (ext) begin
         if (b == 'h4A) return 'h2F;
         if (b == 'h5A) return -3;
         return -1;
      end
      case (b)
         'h1C: return "a";  'h32: return "b";  'h21: return "c";  'h23: return "d";
         'h24: return "e";  'h2B: return "f";  'h34: return "g";  'h33: return "h";
         'h43: return "i";  'h3B: return "j";  'h42: return "k";  'h4B: return "l";
         'h3A: return "m";  'h31: return "n";  'h44: return "o";  'h4D: return "p";
         'h15: return "q";  'h2D: return "r";  'h1B: return "s";  'h2C: return "t";
         'h3C: return "u";  'h2A: return "v";  'h1D: return "w";  'h22: return "x";
         'h35: return "y";  'h1A: return "z";
         'h45: return "0";  'h16: return "1";  'h1E: return "2";  'h26: return "3";
         'h25: return "4";  'h2E: return "5";  'h36: return "6";  'h3D: return "7";
         'h3E: return "8";  'h46: return "9";
         'h29: return " ";  'h41: return ",";  'h49: return ".";  'h4A: return "/";
         'h4E: return "-";  'h55: return "=";  'h7C: return "*";  'h79: return "+";
         'h7B: return "-";
         'h66: return -2;
         'h5A: return -3;
         default: return -1;
      endcase
   endfunction

   function automatic int observed();
      if (char_req) return int'(char_out);
      if (bksp_req) return -2;
      if (run_req)  return -3;
      return -1;
   endfunction

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      key_stb  = 1'b1;
      key_code = b;
      @(negedge clk);
      key_stb  = 1'b0;
   endtask

   task automatic expect_quiet(input string tag);
      check(!char_req && !bksp_req && !run_req, tag,
            {char_req, bksp_req, run_req}, 0);
   endtask

   // finish whatever handshake is open, checking the hold and release rules
   task automatic complete(input int kind);
      if (kind == -3) begin
         @(negedge clk);
         check(run_req == 1'b1, "R5 run held", run_req, 1);
         run_done = 1'b1;
         @(negedge clk);
         check(run_req == 1'b0, "R5 run drop", run_req, 0);
         send(8'h1C);  // R9 ignored: run_done still high
         run_done = 1'b0;
         @(negedge clk);
         @(negedge clk);
         expect_quiet("R5 R9 wait run_done low");
      end else if (kind >= 0 || kind == -2) begin
         send(8'h32);  // R9: strobe while busy
         if (kind >= 0)
            check(char_req && char_out == kind[7:0], "R3 hold",
                  int'(char_out), kind);
         else
            check(bksp_req && char_out == 8'h00, "R4 hold", int'(char_out), 0);
         hist_ack = 1'b1;
         @(negedge clk);
         check(!char_req && !bksp_req, "R3 drop", {char_req, bksp_req}, 0);
         send(8'h1C);  // R3: ack still high, byte ignored
         hist_ack = 1'b0;
         @(negedge clk);
         @(negedge clk);
         expect_quiet("R9 busy bytes ignored");
      end
   endtask

   task automatic run_key(input int b, input bit ext, input string tag);
      int e;
      int a;
      if (ext) send(8'hE0);
      send(b[7:0]);
      e = exp_key(b, ext);
      a = observed();
      check(a == e, tag, a, e);
      check($onehot0({char_req, bksp_req, run_req}), "R9 onehot",
            {char_req, bksp_req, run_req}, 0);
      complete(a);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      expect_quiet("R1 reset requests");
      check(char_out == 8'h00, "R1 reset char", int'(char_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      expect_quiet("R1 after reset");

      // R2 R4 R5 R8: every plain byte
      for (int b = 0; b < 256; b++) begin
         if (b != 'hE0 && b != 'hF0) run_key(b, 1'b0, "R2 R8 plain sweep");
      end

      // R6: every extended byte
      for (int b = 0; b < 256; b++) begin
         if (b != 'hE0 && b != 'hF0) run_key(b, 1'b1, "R6 extended sweep");
      end

      // R7: release marker discards next byte
      send(8'hF0);
      send(8'h1C);
      expect_quiet("R7 release discard");
      run_key('h1C, 1'b0, "R7 R10 after release");
      send(8'hE0);
      send(8'hF0);
      send(8'h4A);
      expect_quiet("R7 extended release");
      run_key('h4A, 1'b0, "R10 flags cleared");

      // R10: extended flag clears after one byte
      send(8'hE0);
      send(8'h1C);
      expect_quiet("R10 ext unmapped");
      run_key('h1C, 1'b0, "R10 ext cleared");

      // R9: prefix strobed while busy is ignored
      send(8'h1C);
      check(char_req == 1'b1, "R9 setup", char_req, 1);
      send(8'hE0);
      hist_ack = 1'b1;
      @(negedge clk);
      hist_ack = 1'b0;
      @(negedge clk);
      run_key('h1C, 1'b0, "R9 prefix ignored while busy");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule